// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block is one parameterised bidirectional I/O port of `NPINS` pins (eight by default). Each pin has a direction bit and an output bit. The output bit also serves as the pull-up request while the pin is an input. The value at the pad is sampled through a synchronizer. Software reaches the port through three register addresses: direction, output and pin-input. All pins of the port share one write strobe and one read strobe per address, one write data bus and one read data bus.

An on-chip peripheral can take control of a pin without changing the registers. For each pin it has four enable/value pairs: pull-up, direction, driven level and digital input enable. A per-pin toggle request lets it flip the output bit. Two signals are common to every port: a global pull-up disable and a sleep signal. While sleep is high, the digital input path is closed unless the peripheral overrides the input enable.

The pad is modelled as four separate signals: drive level, drive enable, pull-up enable and sampled input. The synchronized input is also sent to the peripherals. Analog behaviour, drive strength and pin-change interrupts are not part of the block.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction and output registers are zero. Every read returns 0, and `pad_oe` and `pad_pu` are 0 when no override is active.
- R2: A write with `wr_dir` loads `wdata` into the direction register at the next clock edge. Bit n of `pad_oe` equals direction bit n, unless `ovr_dir_en[n]` is 1, in which case it equals `ovr_dir_val[n]`.
- R3: Bit n of `pad_pu` equals `ovr_pu_val[n]` when `ovr_pu_en[n]` is 1. Otherwise it is 1 only when direction bit n is 0, output bit n is 1 and `pu_disable` is 0.
- R4: A write with `wr_port` loads `wdata` into the output register. Bit n of `pad_out` equals output bit n, unless `ovr_out_en[n]` is 1, in which case it equals `ovr_out_val[n]`.
- R5: A write with `wr_pin` inverts each output bit whose `wdata` bit is 1 and leaves the other bits unchanged. A 1 on `ovr_tgl[n]` for one cycle also inverts output bit n. When both request the same bit in one cycle, the bit is inverted only once.
- R6: Bit n of the digital input enable is `ovr_ie_val[n]` when `ovr_ie_en[n]` is 1, and otherwise it is the inverse of `sleep`. A disabled input feeds 0 into the synchronizer.
- R7: A `wr_port` write in the same cycle as any toggle request (`wr_pin` or `ovr_tgl`) wins. The output register takes `wdata`.
- R8: The gated pad input passes through a two-stage synchronizer. A pad change set up before clock edge k is read back and shown on `din` after edge k+1, and not after edge k.
- R9: `rdata` is the bitwise OR of the direction register (when `rd_dir` is 1), the output register (when `rd_port` is 1) and the synchronized input (when `rd_pin` is 1). It is zero when no read strobe is high.
- R10: `din` always equals the synchronized input value returned by an `rd_pin` read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low reset |
| wr_dir | input | 1 | Write strobe, direction register |
| wr_port | input | 1 | Write strobe, output register |
| wr_pin | input | 1 | Write strobe, pin-input address (toggle) |
| wdata | input | NPINS | Write data |
| rd_dir | input | 1 | Read strobe, direction register |
| rd_port | input | 1 | Read strobe, output register |
| rd_pin | input | 1 | Read strobe, synchronized input |
| rdata | output | NPINS | Read data |
| pu_disable | input | 1 | Global pull-up disable |
| sleep | input | 1 | Global sleep; closes the input path |
| ovr_pu_en | input | NPINS | Pull-up override enable |
| ovr_pu_val | input | NPINS | Pull-up override value |
| ovr_dir_en | input | NPINS | Direction override enable |
| ovr_dir_val | input | NPINS | Direction override value |
| ovr_out_en | input | NPINS | Drive level override enable |
| ovr_out_val | input | NPINS | Drive level override value |
| ovr_ie_en | input | NPINS | Input enable override enable |
| ovr_ie_val | input | NPINS | Input enable override value |
| ovr_tgl | input | NPINS | Peripheral toggle request |
| pad_in | input | NPINS | Level at the pad |
| pad_out | output | NPINS | Drive level to the pad |
| pad_oe | output | NPINS | Drive enable to the pad |
| pad_pu | output | NPINS | Pull-up enable to the pad |
| din | output | NPINS | Synchronized input to peripherals |

## Verification
A wrong bit in the direction or output register shows up at once on `pad_oe`, `pad_out` or `pad_pu` when no override is active. The next read of that address also shows it. A corrupted synchronizer stage reaches `rdata` and `din` within two clock edges. The input tests therefore sample at both edges after a pad change, so that a missing or extra stage is caught. Toggle and write collisions are applied in a single cycle, and the result is read back on the following cycle.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
   // enable/value pair used by every per-pin override
   typedef struct packed {
      logic en;
      logic val;
   } ovr_pair_t;

   function automatic logic pick(input ovr_pair_t o, input logic dflt);
      return o.en ? o.val : dflt;
   endfunction

   localparam int unsigned MAX_PINS = 32;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_port,
   input  logic             wr_pin,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] tgl_req,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] port_q
);
   logic [NPINS-1:0] flip;

   // software toggle and peripheral toggle merge; a shared bit flips once
   assign flip = (wr_pin ? wdata : '0) | tgl_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         port_q <= '0;
      end else begin
         if (wr_dir)
            dir_q <= wdata;
         if (wr_port)
            port_q <= wdata;          // direct write beats any toggle
         else
            port_q <= port_q ^ flip;
      end
   end
endmodule

// File: rtl/gpio_ovr_pin.sv
module gpio_ovr_pin
   import gpio_ovr_pkg::*;
(
   input  logic      dir_bit,
   input  logic      port_bit,
   input  logic      pu_disable,
   input  logic      sleep,
   input  ovr_pair_t o_pu,
   input  ovr_pair_t o_dir,
   input  ovr_pair_t o_out,
   input  ovr_pair_t o_ie,
   output logic      oe,
   output logic      drv,
   output logic      pu,
   output logic      ie
);
   logic pu_norm;

   assign pu_norm = ~dir_bit & port_bit & ~pu_disable;
   assign pu      = pick(o_pu,  pu_norm);
   assign oe      = pick(o_dir, dir_bit);
   assign drv     = pick(o_out, port_bit);
   assign ie      = pick(o_ie,  ~sleep);
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] d,
   output logic [NPINS-1:0] q
);
   logic [NPINS-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_port,
   input  logic             wr_pin,
   input  logic [NPINS-1:0] wdata,
   input  logic             rd_dir,
   input  logic             rd_port,
   input  logic             rd_pin,
   output logic [NPINS-1:0] rdata,
   input  logic             pu_disable,
   input  logic             sleep,
   input  logic [NPINS-1:0] ovr_pu_en,
   input  logic [NPINS-1:0] ovr_pu_val,
   input  logic [NPINS-1:0] ovr_dir_en,
   input  logic [NPINS-1:0] ovr_dir_val,
   input  logic [NPINS-1:0] ovr_out_en,
   input  logic [NPINS-1:0] ovr_out_val,
   input  logic [NPINS-1:0] ovr_ie_en,
   input  logic [NPINS-1:0] ovr_ie_val,
   input  logic [NPINS-1:0] ovr_tgl,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_pu,
   output logic [NPINS-1:0] din
);
   generate
      if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
         $error("gpio_ovr_port: NPINS out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_ovr_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] port_q;
   logic [NPINS-1:0] ie_vec;
   logic [NPINS-1:0] sync_d;
   logic [NPINS-1:0] pin_sync;

   gpio_ovr_regs #(.NPINS(NPINS)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_dir  (wr_dir),
      .wr_port (wr_port),
      .wr_pin  (wr_pin),
      .wdata   (wdata),
      .tgl_req (ovr_tgl),
      .dir_q   (dir_q),
      .port_q  (port_q)
   );

   generate
      for (genvar n = 0; n < NPINS; n++) begin : g_pin
         gpio_ovr_pin i_pin (
            .dir_bit    (dir_q[n]),
            .port_bit   (port_q[n]),
            .pu_disable (pu_disable),
            .sleep      (sleep),
            .o_pu       ('{en: ovr_pu_en[n],  val: ovr_pu_val[n]}),
            .o_dir      ('{en: ovr_dir_en[n], val: ovr_dir_val[n]}),
            .o_out      ('{en: ovr_out_en[n], val: ovr_out_val[n]}),
            .o_ie       ('{en: ovr_ie_en[n],  val: ovr_ie_val[n]}),
            .oe         (pad_oe[n]),
            .drv        (pad_out[n]),
            .pu         (pad_pu[n]),
            .ie         (ie_vec[n])
         );
      end
   endgenerate

   // closed input path presents a steady 0 to the first flop
   assign sync_d = pad_in & ie_vec;

   gpio_ovr_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_d),
      .q     (pin_sync)
   );

   assign din   = pin_sync;
   assign rdata = ({NPINS{rd_dir}}  & dir_q)
                | ({NPINS{rd_port}} & port_q)
                | ({NPINS{rd_pin}}  & pin_sync);
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_dir,
   input logic             wr_port,
   input logic             wr_pin,
   input logic [NPINS-1:0] wdata,
   input logic             rd_dir,
   input logic             rd_port,
   input logic             rd_pin,
   input logic [NPINS-1:0] rdata,
   input logic             pu_disable,
   input logic [NPINS-1:0] ovr_pu_en,
   input logic [NPINS-1:0] ovr_tgl,
   input logic [NPINS-1:0] pad_pu,
   input logic [NPINS-1:0] din,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] port_q,
   input logic [NPINS-1:0] sync_d
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> dir_q == $past(wdata));

   a_r3_pu_off: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_disable && ovr_pu_en == '0) |-> pad_pu == '0);

   a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_port && !wr_pin && ovr_tgl == '0) |=> $stable(port_q));

   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_port |=> port_q == $past(wdata));

   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_dir || rd_port || rd_pin) |-> rdata == '0);

   generate
      if (SYNC_STAGES == 2) begin : g_two
         a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3) |-> din == $past(sync_d, 2));
      end
   endgenerate
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_port(wr_port), .wr_pin(wr_pin),
   .wdata(wdata), .rd_dir(rd_dir), .rd_port(rd_port), .rd_pin(rd_pin), .rdata(rdata),
   .pu_disable(pu_disable), .ovr_pu_en(ovr_pu_en), .ovr_tgl(ovr_tgl), .pad_pu(pad_pu),
   .din(din), .dir_q(dir_q), .port_q(port_q), .sync_d(sync_d)
);

// File: tb/test_gpio_ovr_port.sv
module test_gpio_ovr_port;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_dir = 0, wr_port = 0, wr_pin = 0;
   logic rd_dir = 0, rd_port = 0, rd_pin = 0;
   logic [N-1:0] wdata = '0;
   logic [N-1:0] rdata;
   logic pu_disable = 0, sleep = 0;
   logic [N-1:0] ovr_pu_en = '0, ovr_pu_val = '0, ovr_dir_en = '0, ovr_dir_val = '0;
   logic [N-1:0] ovr_out_en = '0, ovr_out_val = '0, ovr_ie_en = '0, ovr_ie_val = '0;
   logic [N-1:0] ovr_tgl = '0, pad_in = '0;
   logic [N-1:0] pad_out, pad_oe, pad_pu, din;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_ovr_port #(.NPINS(N)) i_gpio_ovr_port (
      .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_port(wr_port), .wr_pin(wr_pin),
      .wdata(wdata), .rd_dir(rd_dir), .rd_port(rd_port), .rd_pin(rd_pin), .rdata(rdata),
      .pu_disable(pu_disable), .sleep(sleep),
      .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
      .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val),
      .ovr_out_en(ovr_out_en), .ovr_out_val(ovr_out_val),
      .ovr_ie_en(ovr_ie_en), .ovr_ie_val(ovr_ie_val),
      .ovr_tgl(ovr_tgl), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .din(din)
   );

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // kind: 0 dir, 1 port, 2 pin
   task automatic wr(input int kind, input logic [N-1:0] d);
      @(negedge clk);
      wdata = d;
      wr_dir = (kind == 0); wr_port = (kind == 1); wr_pin = (kind == 2);
      @(negedge clk);
      wr_dir = 0; wr_port = 0; wr_pin = 0; wdata = '0;
   endtask

   task automatic rd(input int kind, output logic [N-1:0] v);
      @(negedge clk);
      rd_dir = (kind == 0); rd_port = (kind == 1); rd_pin = (kind == 2);
      #1 v = rdata;
      rd_dir = 0; rd_port = 0; rd_pin = 0;
   endtask

   task automatic t_reset();
      logic [N-1:0] v;
      rd(0, v); check("R1 dir", v, 8'h00);
      rd(1, v); check("R1 port", v, 8'h00);
      check("R1 oe", pad_oe, 8'h00);
      check("R1 pu", pad_pu, 8'h00);
      check("R9 idle", rdata, 8'h00);
   endtask

   task automatic t_dir();
      logic [N-1:0] v;
      wr(0, 8'hA5);
      rd(0, v); check("R2 read", v, 8'hA5);
      check("R2 oe", pad_oe, 8'hA5);
      ovr_dir_en = 8'h0F; ovr_dir_val = 8'h03; #1;
      check("R2 override", pad_oe, 8'hA3);
      ovr_dir_en = '0; ovr_dir_val = '0;
      wr(0, 8'h00);
   endtask

   task automatic t_pullup();
      wr(1, 8'hFF); #1;
      check("R3 input+port", pad_pu, 8'hFF);
      pu_disable = 1; #1;
      check("R3 global off", pad_pu, 8'h00);
      ovr_pu_en = 8'h0F; ovr_pu_val = 8'h05; #1;
      check("R3 override", pad_pu, 8'h05);
      ovr_pu_en = '0; ovr_pu_val = '0; pu_disable = 0;
      wr(0, 8'hF0); #1;
      check("R3 outputs no pu", pad_pu, 8'h0F);
      wr(0, 8'h00);
   endtask

   task automatic t_out();
      wr(1, 8'h3C); #1;
      check("R4 drive", pad_out, 8'h3C);
      ovr_out_en = 8'hF0; ovr_out_val = 8'h50; #1;
      check("R4 override", pad_out, 8'h5C);
      ovr_out_en = '0; ovr_out_val = '0;
   endtask

   task automatic t_toggle();
      logic [N-1:0] v;
      wr(1, 8'h3C);
      wr(2, 8'h0F); rd(1, v); check("R5 sw toggle", v, 8'h33);
      wr(2, 8'h00); rd(1, v); check("R5 zero no effect", v, 8'h33);
      @(negedge clk); ovr_tgl = 8'h81; @(negedge clk); ovr_tgl = '0;
      rd(1, v); check("R5 periph toggle", v, 8'hB2);
      @(negedge clk); ovr_tgl = 8'h01; wdata = 8'h01; wr_pin = 1;
      @(negedge clk); ovr_tgl = '0; wdata = '0; wr_pin = 0;
      rd(1, v); check("R5 single flip", v, 8'hB3);
   endtask

   task automatic t_write_wins();
      logic [N-1:0] v;
      @(negedge clk); ovr_tgl = 8'hFF; wdata = 8'h55; wr_port = 1;
      @(negedge clk); ovr_tgl = '0; wdata = '0; wr_port = 0;
      rd(1, v); check("R7 vs periph", v, 8'h55);
      @(negedge clk); wdata = 8'h66; wr_port = 1; wr_pin = 1;
      @(negedge clk); wdata = '0; wr_port = 0; wr_pin = 0;
      rd(1, v); check("R7 vs sw", v, 8'h66);
   endtask

   task automatic t_sync();
      logic [N-1:0] v;
      pad_in = 8'h00;
      repeat (3) @(negedge clk);
      pad_in = 8'hA5;
      rd(2, v); check("R8 one edge", v, 8'h00);
      rd(2, v); check("R8 two edges", v, 8'hA5);
      check("R10 din", din, 8'hA5);
   endtask

   task automatic t_sleep();
      logic [N-1:0] v;
      sleep = 1; pad_in = 8'hFF;
      repeat (3) @(negedge clk);
      rd(2, v); check("R6 sleep closed", v, 8'h00);
      ovr_ie_en = 8'h0F; ovr_ie_val = 8'h0F;
      repeat (3) @(negedge clk);
      rd(2, v); check("R6 override open", v, 8'h0F);
      sleep = 0; ovr_ie_en = 8'hF0; ovr_ie_val = 8'h00;
      repeat (3) @(negedge clk);
      rd(2, v); check("R6 override closed", v, 8'h0F);
      check("R10 din", din, 8'h0F);
      ovr_ie_en = '0; ovr_ie_val = '0;
   endtask

   task automatic t_readbus();
      logic [N-1:0] v;
      wr(0, 8'h81); wr(1, 8'h18);
      @(negedge clk); rd_dir = 1; rd_port = 1; #1 v = rdata;
      rd_dir = 0; rd_port = 0;
      check("R9 or-combine", v, 8'h99);
      #1 check("R9 idle", rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_dir();
      t_pullup();
      t_out();
      t_toggle();
      t_write_wins();
      t_sync();
      t_sleep();
      t_readbus();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule